// File: doc/BRIEF.md
# Printer Strobe and Drive Select Decoder

This block sits beside the register file of a sound generator that has two general-purpose output ports. It watches the register write bus. When software writes the port A register, the block looks for a high-to-low change of a strobe bit, comparing the new value with the strobe value from the previous port A write. The strobe is not sampled from a wire. When printing is enabled, that falling edge hands the current port B byte to a parallel printer. The hand-off is a one-cycle byte-valid pulse, joined by a busy-interrupt pulse. On the extended machine variant, it is also joined by an acknowledge-interrupt pulse.

The same port A writes also drive two registered drive-select indicators. Each indicator shows "drive on" when its port A bit is written as zero. The block keeps its own copy of port B, which it captures from writes to the port B register. The remembered strobe value and the indicators change only on port A writes. All other register writes leave them untouched.

Top module: `prn_strobe_decoder`

## Requirements
- R1: After reset, all outputs are 0 and the remembered strobe is 0. A first port A write with the strobe bit low therefore makes no transfer.
- R2: A write to register index 14 (port A) with bit 5 equal to 0 starts a transfer when three conditions hold. The previous port A write had bit 5 equal to 1. Input `print_en` is high in the write cycle. The transfer is a one-cycle high on `byte_valid` in the cycle after the write.
- R3: While `print_en` is low, no port A write causes a transfer.
- R4: Every port A write updates the remembered strobe bit, whatever the state of `print_en`.
- R5: `byte_out` carries the byte from the most recent write to register index 15 (port B) during each `byte_valid` pulse.
- R6: Every transfer pulses `busy_irq` in the same cycle as `byte_valid`, and `busy_irq` never pulses without a transfer.
- R7: `ack_irq` pulses together with a transfer only if `ext_machine` was high in the write cycle. Otherwise it stays low.
- R8: `drive_a_on` is 1 when the last port A write had bit 1 equal to 0. `drive_b_on` is 1 when that write had bit 2 equal to 0. Both are registered levels that change only in the cycle after a port A write.
- R9: Writes to any register index other than 14 never cause a transfer and never change the remembered strobe or the indicators. This includes indices of 16 and above whose low four bits equal 14.
- R10: `byte_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index being written |
| wr_data | input | 8 | Register write data |
| print_en | input | 1 | Printing enabled |
| ext_machine | input | 1 | Extended machine variant, adds the acknowledge interrupt |
| byte_out | output | 8 | Byte handed to the printer |
| byte_valid | output | 1 | One-cycle pulse, byte_out is valid |
| busy_irq | output | 1 | One-cycle busy interrupt pulse |
| ack_irq | output | 1 | One-cycle acknowledge interrupt pulse |
| drive_a_on | output | 1 | Drive A selected indicator |
| drive_b_on | output | 1 | Drive B selected indicator |

## Verification
Directed sequences cover five cases:
- a low strobe written first after reset, which separates a correctly cleared remembered strobe from one that powers up high;
- a high-then-low pair with printing on and with printing off, which separates edge gating from edge tracking;
- an alias index of 46, which catches decoding that uses only the low four bits;
- a port B rewrite between strobes, which shows that the byte comes from the port B copy and not from the port A data;
- the same edge sent on both machine variants.

Random stimulus mixes writes to both ports, writes to foreign indices and idle cycles, while toggling the enable and the variant. A bench model checks every output in every cycle. This catches off-by-one timing, pulses that are held too long, and indicator updates made on the wrong writes.

// File: rtl/prn_strobe_pkg.sv
package prn_strobe_pkg;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned BYTE_W  = 8;

  // Event produced by the edge detector, consumed by the output stage.
  typedef struct packed {
    logic fire;
    logic ext;
  } xfer_evt_t;
endpackage

// File: rtl/prn_port_regs.sv
module prn_port_regs #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned PA_IDX = 14,
  parameter int unsigned PB_IDX = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic             pa_wr,
  output logic [DW-1:0]    pa_val,
  output logic [DW-1:0]    pb_q
);
  localparam logic [IDX_W-1:0] PA_SEL = IDX_W'(PA_IDX);
  localparam logic [IDX_W-1:0] PB_SEL = IDX_W'(PB_IDX);

  logic pb_wr;

  // Full-width compare: aliases above the register range never match.
  always_comb begin
    pa_wr  = wr_en && (wr_idx == PA_SEL);
    pb_wr  = wr_en && (wr_idx == PB_SEL);
    pa_val = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        pb_q <= '0;
    else if (pb_wr) pb_q <= wr_data;
  end
endmodule

// File: rtl/prn_edge_detect.sv
module prn_edge_detect
  import prn_strobe_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned STB_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pa_wr,
  input  logic [DW-1:0] pa_val,
  input  logic          print_en,
  input  logic          ext_machine,
  output xfer_evt_t     evt
);
  logic prev_stb;

  // The remembered strobe tracks every port A write, printing or not.
  always_ff @(posedge clk) begin
    if (rst)        prev_stb <= 1'b0;
    else if (pa_wr) prev_stb <= pa_val[STB_BIT];
  end

  always_comb begin
    evt.fire = pa_wr && print_en && prev_stb && !pa_val[STB_BIT];
    evt.ext  = ext_machine;
  end
endmodule

// File: rtl/prn_pulse_out.sv
module prn_pulse_out
  import prn_strobe_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  xfer_evt_t     evt,
  input  logic [DW-1:0] pb_q,
  output logic [DW-1:0] byte_out,
  output logic          byte_valid,
  output logic          busy_irq,
  output logic          ack_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out   <= '0;
      byte_valid <= 1'b0;
      busy_irq   <= 1'b0;
      ack_irq    <= 1'b0;
    end else begin
      byte_valid <= evt.fire;
      busy_irq   <= evt.fire;
      ack_irq    <= evt.fire && evt.ext;
      if (evt.fire) byte_out <= pb_q;
    end
  end
endmodule

// File: rtl/prn_drive_ind.sv
module prn_drive_ind #(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_DRV = 2,
  parameter int unsigned BASE  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pa_wr,
  input  logic [DW-1:0]    pa_val,
  output logic [N_DRV-1:0] drv_on
);
  // One registered active-low decode per drive bit.
  for (genvar g = 0; g < N_DRV; g++) begin : g_drv
    always_ff @(posedge clk) begin
      if (rst)        drv_on[g] <= 1'b0;
      else if (pa_wr) drv_on[g] <= ~pa_val[BASE + g];
    end
  end
endmodule

// File: rtl/prn_strobe_decoder.sv
module prn_strobe_decoder
  import prn_strobe_pkg::*;
#(
  parameter int unsigned IDX_W   = prn_strobe_pkg::IDX_W,
  parameter int unsigned DW      = prn_strobe_pkg::BYTE_W,
  parameter int unsigned PA_IDX  = 14,
  parameter int unsigned PB_IDX  = 15,
  parameter int unsigned STB_BIT = 5,
  parameter int unsigned DRV_LSB = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             print_en,
  input  logic             ext_machine,
  output logic [DW-1:0]    byte_out,
  output logic             byte_valid,
  output logic             busy_irq,
  output logic             ack_irq,
  output logic             drive_a_on,
  output logic             drive_b_on
);
  localparam int unsigned N_DRV = 2;

  logic             pa_wr;
  logic [DW-1:0]    pa_val;
  logic [DW-1:0]    pb_q;
  xfer_evt_t        evt;
  logic [N_DRV-1:0] drv_on;

  prn_port_regs #(.IDX_W(IDX_W), .DW(DW), .PA_IDX(PA_IDX), .PB_IDX(PB_IDX)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pa_wr(pa_wr), .pa_val(pa_val), .pb_q(pb_q)
  );

  prn_edge_detect #(.DW(DW), .STB_BIT(STB_BIT)) u_edge (
    .clk(clk), .rst(rst), .pa_wr(pa_wr), .pa_val(pa_val),
    .print_en(print_en), .ext_machine(ext_machine), .evt(evt)
  );

  prn_pulse_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .evt(evt), .pb_q(pb_q),
    .byte_out(byte_out), .byte_valid(byte_valid),
    .busy_irq(busy_irq), .ack_irq(ack_irq)
  );

  prn_drive_ind #(.DW(DW), .N_DRV(N_DRV), .BASE(DRV_LSB)) u_drv (
    .clk(clk), .rst(rst), .pa_wr(pa_wr), .pa_val(pa_val), .drv_on(drv_on)
  );

  assign drive_a_on = drv_on[0];
  assign drive_b_on = drv_on[1];
endmodule

// File: rtl/prn_strobe_checker.sv
module prn_strobe_checker #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned PA_IDX  = 14,
  parameter int unsigned STB_BIT = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic             print_en,
  input logic             ext_machine,
  input logic             byte_valid,
  input logic             busy_irq,
  input logic             ack_irq,
  input logic             drive_a_on,
  input logic             drive_b_on
);
  logic pa_hit;
  assign pa_hit = wr_en && (wr_idx == IDX_W'(PA_IDX));

  p_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(print_en) && $past(pa_hit) && !$past(wr_data[STB_BIT]));

  p_busy_match_r6: assert property (@(posedge clk) disable iff (rst)
    byte_valid == busy_irq);

  p_ack_variant_r7: assert property (@(posedge clk) disable iff (rst)
    ack_irq |-> busy_irq && $past(ext_machine));

  p_drive_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pa_hit)) |-> ($stable(drive_a_on) && $stable(drive_b_on)));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
endmodule

bind prn_strobe_decoder prn_strobe_checker #(
  .IDX_W(IDX_W), .DW(DW), .PA_IDX(PA_IDX), .STB_BIT(STB_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .print_en(print_en), .ext_machine(ext_machine), .byte_valid(byte_valid),
  .busy_irq(busy_irq), .ack_irq(ack_irq),
  .drive_a_on(drive_a_on), .drive_b_on(drive_b_on)
);

// File: tb/sim_prn_strobe_decoder.sv
`timescale 1ns/1ps
module sim_prn_strobe_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       print_en = 1'b0;
  logic       ext_machine = 1'b0;
  logic [7:0] byte_out;
  logic       byte_valid, busy_irq, ack_irq, drive_a_on, drive_b_on;

  always #2 clk = ~clk;

  prn_strobe_decoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .print_en(print_en), .ext_machine(ext_machine), .byte_out(byte_out),
    .byte_valid(byte_valid), .busy_irq(busy_irq), .ack_irq(ack_irq),
    .drive_a_on(drive_a_on), .drive_b_on(drive_b_on)
  );

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 0;

  // Bench model state
  bit       m_prev;
  bit [7:0] m_pb;
  bit       m_da, m_db;
  bit [7:0] m_last_byte;

  function automatic bit exp_fire(bit we, bit [7:0] idx, bit [7:0] d, bit en, bit prev);
    return we && idx == 8'd14 && en && prev && !d[5];
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check just after the next posedge.
  task automatic step(bit we, bit [7:0] idx, bit [7:0] d, bit en, bit ext);
    bit f;
    wr_en = we; wr_idx = idx; wr_data = d; print_en = en; ext_machine = ext;
    f = exp_fire(we, idx, d, en, m_prev);
    if (f) m_last_byte = m_pb;
    if (we && idx == 8'd14) begin
      m_prev = d[5]; m_da = !d[1]; m_db = !d[2];
    end
    if (we && idx == 8'd15) m_pb = d;
    @(posedge clk); #1;
    chk(idx == 8'd14 ? "R2" : "R9", byte_valid, f);
    chk("R6", busy_irq, f);
    chk("R7", ack_irq, f && ext);
    if (f) chk("R5", byte_out, m_last_byte);
    chk("R8", drive_a_on, m_da);
    chk("R8", drive_b_on, m_db);
    @(negedge clk);
  endtask

  initial begin
    m_prev = 0; m_pb = 0; m_da = 0; m_db = 0; m_last_byte = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", byte_valid, 0); chk("R1", busy_irq, 0); chk("R1", ack_irq, 0);
    chk("R1", drive_a_on, 0); chk("R1", drive_b_on, 0);
    // R1: a low strobe as the first port A write does not transfer
    step(1, 14, 8'h00, 1, 0);
    step(0, 0, 0, 1, 0);
    // R5: load port B, then R2 falling edge with printing on
    step(1, 15, 8'hA5, 1, 0);
    step(1, 14, 8'h26, 1, 0);
    step(1, 14, 8'h06, 1, 0);
    step(0, 0, 0, 1, 0);
    // R3/R4: edge with printing off updates the strobe, so no later transfer
    step(1, 14, 8'h20, 0, 0);
    step(1, 14, 8'h00, 0, 0);
    step(1, 14, 8'h00, 1, 0);
    // R9: alias index 46 and port B writes do not touch the strobe
    step(1, 14, 8'h20, 1, 0);
    step(1, 46, 8'h00, 1, 0);
    step(1, 15, 8'h3C, 1, 0);
    // R7: extended machine adds acknowledge
    step(1, 14, 8'h00, 1, 1);
    step(1, 14, 8'h20, 1, 1);
    step(1, 14, 8'h04, 1, 0);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit [7:0] idx;
      r = $urandom_range(0, 99);
      if (r < 50) idx = 8'd14;
      else if (r < 70) idx = 8'd15;
      else if (r < 80) idx = 8'd46;
      else idx = 8'($urandom_range(0, 255));
      step($urandom_range(0, 9) < 8, idx, 8'($urandom),
           $urandom_range(0, 9) < 7, 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule